// File: doc/BRIEF.md
# Banked Program Counter Unit

This unit produces the 15-bit instruction address of a small microcontroller core. The address space holds four program banks of 8K words each. The lower 13 address bits give the word offset inside a bank. A 2-bit bank register, loaded by its own write strobe, supplies the upper two bits whenever a jump or call loads the counter. The jump or call instruction therefore carries only the in-bank offset.

Calls and interrupt entry save the address of the next sequential instruction on an 8-entry hardware stack, and a return restores the counter from that stack. Interrupt entry always goes to a fixed vector in bank 0, whatever the bank register holds. When the stack is already full, a further push overwrites the oldest entry. A return with nothing on the stack leaves the counter where it is. Each of these two events sets a sticky flag.

When several control inputs are high in the same cycle, the unit acts on one of them by a fixed priority. The instruction decoder drives the control inputs. The address output feeds program memory.

Top module: `pc_bank_unit`

## Requirements
- R1: After reset, the address is 0, the bank register holds 0, and both stack flags are low.
- R2: With only `incEn` high, the address rises by one in the next cycle, and 0x7FFF wraps to 0x0000.
- R3: A cycle with `bankWrEn` high loads `bankWrData` into the bank register. A jump in that same cycle still uses the bank value held before the write.
- R4: A jump loads the address with {bank register, `tgtOffset`}.
- R5: A call loads the address as a jump does, and pushes the current address plus one (15-bit wrap) onto the stack.
- R6: Interrupt entry loads {2'b00, vector}, with the vector 0x0004 by default. It pushes the current address plus one and ignores the bank register.
- R7: A return with a non-empty stack loads the most recently pushed address, so entries come back in LIFO order.
- R8: A push with 8 entries already held overwrites the oldest entry and sets the sticky `stkOvf` flag. The next 8 returns give back the 8 newest pushes.
- R9: A return with an empty stack leaves the address unchanged and sets the sticky `stkUnd` flag.
- R10: When several inputs are high together, the unit acts on only one, in this order: interrupt, call, jump, return, increment.
- R11: With no control input high, the address holds its value. A bank write alone does not change the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| incEn | input | 1 | Step to the next sequential address |
| jmpEn | input | 1 | Jump to the in-bank offset |
| callEn | input | 1 | Call the in-bank offset and push the return address |
| irqEn | input | 1 | Enter the interrupt vector and push the return address |
| retEn | input | 1 | Return to the address on top of the stack |
| bankWrEn | input | 1 | Write strobe for the bank register |
| bankWrData | input | 2 | New bank register value |
| tgtOffset | input | 13 | In-bank offset for a jump or call |
| pcAddr | output | 15 | Current instruction address |
| stkOvf | output | 1 | Sticky flag: a push overwrote the oldest entry |
| stkUnd | output | 1 | Sticky flag: a return found the stack empty |

## Verification
The bench writes the bank register and jumps in the same cycle. A design that forwards the new bank value would land in the wrong bank. It raises every control input at once to check the priority order. A wrong order would take a call or return where the interrupt belongs, and would also push or pop the stack when it should not. Calls are made at 0x7FFF and steps are taken from 0x7FFF, so a return address or increment that carries out of 15 bits shows up as a wrong address. Nine nested calls followed by nine returns probe the overwrite and empty-stack cases. A stack pointer that does not wrap, or a count that does not saturate, returns stale addresses or moves the counter on an empty pop.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  // one-cycle action strobes from control to datapath; at most one action per cycle
  typedef struct packed {
    logic inc;   // step to next sequential address
    logic jump;  // load {bank, offset} (jump or call)
    logic irq;   // load interrupt vector in bank 0
    logic push;  // save next sequential address on the stack
    logic pop;   // restore address from the stack
  } pcStrobe_t;
endpackage

// File: rtl/pcu_ctrl.sv
module pcu_ctrl
  import pcu_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             incEn,
  input  logic             jmpEn,
  input  logic             callEn,
  input  logic             irqEn,
  input  logic             retEn,
  output pcStrobe_t        strb,
  output logic [PTR_W-1:0] wrIdx,
  output logic [PTR_W-1:0] rdIdx,
  output logic             stkOvf,
  output logic             stkUnd
);
  logic [PTR_W-1:0] top;
  logic [CNT_W-1:0] cnt;
  logic             stkEmpty;
  logic             stkFull;
  logic             undEvt;

  assign stkEmpty = (cnt == '0);
  assign stkFull  = (cnt == CNT_W'(DEPTH));
  assign wrIdx    = top;
  assign rdIdx    = (top == '0) ? PTR_W'(DEPTH - 1) : top - 1'b1;

  // fixed priority: interrupt > call > jump > return > increment
  always_comb begin
    strb   = '0;
    undEvt = 1'b0;
    if (irqEn) begin
      strb.irq  = 1'b1;
      strb.push = 1'b1;
    end else if (callEn) begin
      strb.jump = 1'b1;
      strb.push = 1'b1;
    end else if (jmpEn) begin
      strb.jump = 1'b1;
    end else if (retEn) begin
      if (stkEmpty) undEvt = 1'b1;
      else          strb.pop = 1'b1;
    end else if (incEn) begin
      strb.inc = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      top    <= '0;
      cnt    <= '0;
      stkOvf <= 1'b0;
      stkUnd <= 1'b0;
    end else begin
      if (strb.push) begin
        top <= (top == PTR_W'(DEPTH - 1)) ? '0 : top + 1'b1;
        if (stkFull) stkOvf <= 1'b1;
        else         cnt    <= cnt + 1'b1;
      end else if (strb.pop) begin
        top <= rdIdx;
        cnt <= cnt - 1'b1;
      end
      if (undEvt) stkUnd <= 1'b1;
    end
  end

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(DEPTH));
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    stkOvf |=> stkOvf);
  // R9
  und_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    stkUnd |=> stkUnd);
  // R9
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> !stkEmpty);
  // R10
  one_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.inc, strb.jump, strb.irq, strb.pop}));
endmodule

// File: rtl/pcu_datapath.sv
module pcu_datapath
  import pcu_pkg::*;
#(
  parameter int PC_W  = 15,
  parameter int OFF_W = 13,
  parameter int DEPTH = 8,
  parameter logic [OFF_W-1:0] IRQ_VEC = 'h4,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int BANK_W = PC_W - OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  pcStrobe_t         strb,
  input  logic [PTR_W-1:0]  wrIdx,
  input  logic [PTR_W-1:0]  rdIdx,
  input  logic              bankWrEn,
  input  logic [BANK_W-1:0] bankWrData,
  input  logic [OFF_W-1:0]  tgtOffset,
  output logic [PC_W-1:0]   pcAddr
);
  localparam logic [PC_W-1:0] IRQ_ADDR = {BANK_W'(0), IRQ_VEC};

  logic [PC_W-1:0]   pc;
  logic [PC_W-1:0]   pcSeq;
  logic [BANK_W-1:0] bank;
  logic [PC_W-1:0]   stk [DEPTH];

  assign pcSeq  = pc + 1'b1;
  assign pcAddr = pc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bank <= '0;
    else if (bankWrEn) bank <= bankWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          pc <= '0;
    else if (strb.irq)  pc <= IRQ_ADDR;
    else if (strb.jump) pc <= {bank, tgtOffset};
    else if (strb.pop)  pc <= stk[rdIdx];
    else if (strb.inc)  pc <= pcSeq;
  end

  always_ff @(posedge clk) begin
    if (strb.push) stk[wrIdx] <= pcSeq;
  end

  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.inc |=> pc == PC_W'($past(pc) + 1'b1));
  // R6
  irq_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.irq |=> pc == IRQ_ADDR);
  // R4
  jump_bank_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.jump |=> pc[PC_W-1:OFF_W] == $past(bank));
  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb == '0) |=> $stable(pc));
endmodule

// File: rtl/pc_bank_unit.sv
module pc_bank_unit
  import pcu_pkg::*;
#(
  parameter int PC_W  = 15,
  parameter int OFF_W = 13,
  parameter int DEPTH = 8,
  parameter logic [OFF_W-1:0] IRQ_VEC = 'h4,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int BANK_W = PC_W - OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              incEn,
  input  logic              jmpEn,
  input  logic              callEn,
  input  logic              irqEn,
  input  logic              retEn,
  input  logic              bankWrEn,
  input  logic [BANK_W-1:0] bankWrData,
  input  logic [OFF_W-1:0]  tgtOffset,
  output logic [PC_W-1:0]   pcAddr,
  output logic              stkOvf,
  output logic              stkUnd
);
  pcStrobe_t        strb;
  logic [PTR_W-1:0] wrIdx;
  logic [PTR_W-1:0] rdIdx;

  pcu_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .incEn(incEn), .jmpEn(jmpEn), .callEn(callEn),
    .irqEn(irqEn), .retEn(retEn), .strb(strb), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .stkOvf(stkOvf), .stkUnd(stkUnd)
  );

  pcu_datapath #(.PC_W(PC_W), .OFF_W(OFF_W), .DEPTH(DEPTH), .IRQ_VEC(IRQ_VEC)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .bankWrEn(bankWrEn), .bankWrData(bankWrData), .tgtOffset(tgtOffset),
    .pcAddr(pcAddr)
  );
endmodule

// File: tb/pc_bank_unit_test.sv
`timescale 1ns/1ps
module pc_bank_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        incEn = 0, jmpEn = 0, callEn = 0, irqEn = 0, retEn = 0, bankWrEn = 0;
  logic [1:0]  bankWrData = '0;
  logic [12:0] tgtOffset = '0;
  logic [14:0] pcAddr;
  logic        stkOvf, stkUnd;
  int          nChk = 0;
  int          nFail = 0;

  always #2 clk = ~clk;

  pc_bank_unit uut (
    .clk(clk), .rstN(rstN), .incEn(incEn), .jmpEn(jmpEn), .callEn(callEn),
    .irqEn(irqEn), .retEn(retEn), .bankWrEn(bankWrEn), .bankWrData(bankWrData),
    .tgtOffset(tgtOffset), .pcAddr(pcAddr), .stkOvf(stkOvf), .stkUnd(stkUnd)
  );

  // vector: [35:30] {irq,call,jmp,ret,inc,bankWr}, [29:28] bank data, [27:15] offset, [14:0] expected address
  localparam int NV = 17;
  localparam logic [35:0] VEC [NV] = '{
    {6'b000010, 2'd0, 13'h0000, 15'h0001},  // R2 step
    {6'b000010, 2'd0, 13'h0000, 15'h0002},  // R2 step
    {6'b000001, 2'd2, 13'h0000, 15'h0002},  // R11 bank write alone holds
    {6'b001000, 2'd0, 13'h0100, 15'h4100},  // R4 jump into bank 2
    {6'b000010, 2'd0, 13'h0000, 15'h4101},  // R2
    {6'b010000, 2'd0, 13'h0020, 15'h4020},  // R5 call, pushes 0x4102
    {6'b000010, 2'd0, 13'h0000, 15'h4021},  // R2
    {6'b000100, 2'd0, 13'h0000, 15'h4102},  // R7 return
    {6'b001001, 2'd3, 13'h0010, 15'h4010},  // R3 same-cycle write uses old bank
    {6'b001000, 2'd0, 13'h0010, 15'h6010},  // R3 new bank now in effect
    {6'b111110, 2'd0, 13'h1234, 15'h0004},  // R6 R10 interrupt wins, pushes 0x6011
    {6'b011010, 2'd0, 13'h1FFF, 15'h7FFF},  // R10 call over jump, pushes 0x0005
    {6'b000010, 2'd0, 13'h0000, 15'h0000},  // R2 wrap
    {6'b001110, 2'd0, 13'h0000, 15'h6000},  // R10 jump over return
    {6'b000110, 2'd0, 13'h0000, 15'h0005},  // R10 return over increment
    {6'b000100, 2'd0, 13'h0000, 15'h6011},  // R7 LIFO
    {6'b000100, 2'd0, 13'h0000, 15'h6011}   // R9 empty return holds
  };
  localparam int VREQ [NV] = '{2, 2, 11, 4, 2, 5, 2, 7, 3, 3, 6, 10, 2, 10, 10, 7, 9};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // drive one cycle of inputs after a falling edge, then sample at the next falling edge
  task automatic step(input logic [5:0] ctl, input logic [1:0] bd, input logic [12:0] tgt);
    {irqEn, callEn, jmpEn, retEn, incEn, bankWrEn} = ctl;
    bankWrData = bd;
    tgtOffset  = tgt;
    @(negedge clk);
    {irqEn, callEn, jmpEn, retEn, incEn, bankWrEn} = '0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    nFail++;
    nChk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();
    // R1 reset state
    chk("R1 address", 32'(pcAddr), 32'h0);
    chk("R1 ovf", 32'(stkOvf), 32'h0);
    chk("R1 und", 32'(stkUnd), 32'h0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][35:30], VEC[i][29:28], VEC[i][27:15]);
      chk($sformatf("R%0d vector %0d", VREQ[i], i), 32'(pcAddr), 32'(VEC[i][14:0]));
    end
    chk("R9 und flag", 32'(stkUnd), 32'h1);
    chk("R8 ovf stays low", 32'(stkOvf), 32'h0);

    // R1 bank register reset: jump lands in bank 0
    doReset();
    step(6'b001000, 2'd0, 13'h0055);
    chk("R1 bank reset", 32'(pcAddr), 32'h0055);

    // R5 call at 0x7FFF pushes wrapped 0x0000
    step(6'b000001, 2'd3, 13'h0);
    step(6'b001000, 2'd0, 13'h1FFF);
    step(6'b010000, 2'd0, 13'h0100);
    chk("R5 call target", 32'(pcAddr), 32'h6100);
    step(6'b000100, 2'd0, 13'h0);
    chk("R5 wrapped return address", 32'(pcAddr), 32'h0000);

    // R8 overflow: nine nested calls, pushes 0x01,0x11,...,0x81
    doReset();
    for (int k = 1; k <= 9; k++) begin
      step(6'b010000, 2'd0, 13'(k * 16));
      if (k == 8) chk("R8 no ovf at 8", 32'(stkOvf), 32'h0);
    end
    chk("R8 ovf set", 32'(stkOvf), 32'h1);
    for (int k = 8; k >= 1; k--) begin
      step(6'b000100, 2'd0, 13'h0);
      chk("R8 newest eight", 32'(pcAddr), 32'(k * 16 + 1));
    end
    chk("R9 no und yet", 32'(stkUnd), 32'h0);
    step(6'b000110, 2'd0, 13'h0);
    chk("R9 empty pop holds", 32'(pcAddr), 32'h0011);
    chk("R9 und set", 32'(stkUnd), 32'h1);

    // R11 idle holds
    step(6'b000000, 2'd0, 13'h1AAA);
    chk("R11 idle", 32'(pcAddr), 32'h0011);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule